// File: doc/BRIEF.md
# I2S Stereo Audio Transmitter

This block turns a stream of stereo PCM frames into a serial I2S bit stream and drives the clocks for that stream. It divides the system clock by a static value to make the bit clock (BCLK). It derives the word-select clock (WS) from a slot count. Every word goes out MSB first, with the left word before the right word. Each word starts one bit clock after the WS edge that announces its channel. BCLK is a plain register output that toggles on an internal enable. No logic runs on it as a clock.

An upstream producer offers one left/right pair at a time on a valid/ready input. The pair lands in a one-entry holding register. The transmitter takes it from there at the start of each frame. If the holding register is empty at that moment, both words of the frame are sent as zeros and framing carries on unchanged. A sticky underrun flag is then set and, when the interrupt is enabled, a one-cycle interrupt pulse fires.

The framing controller has three states. `ST_IDLE` is held from reset until the first falling BCLK. `ST_LEFT` covers the left-channel slots and `ST_RIGHT` the right-channel slots. Transition START moves IDLE to LEFT on the first falling BCLK and opens the first frame. Transition SWAP_R moves LEFT to RIGHT on the falling BCLK that ends the last left slot. Transition SWAP_L moves RIGHT to LEFT on the falling BCLK that ends the last right slot, and it opens the next frame.

Top module: `i2s_stereo_tx`

## Requirements
- R1: BCLK stays high and low for `half_div_i + 1` system clock cycles each, so one BCLK period lasts `2*(half_div_i+1)` cycles; BCLK is low while reset is applied.
- R2: WS is low during the left channel and high during the right channel, spans exactly SAMPLE_W (default 16) BCLK periods per channel, and changes only in the cycle where BCLK falls.
- R3: Serial data changes only when BCLK falls; each word is sent MSB first, with its MSB in the BCLK period after the WS edge for its channel and its LSB in the period in which WS changes again.
- R4: Each accepted frame appears on the line as one left word (WS low) followed by its right word (WS high), and frames leave in the order they were accepted.
- R5: A frame is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both high; `in_ready_o` is low while the holding register is occupied and rises again once the frame has been taken at a frame boundary.
- R6: If the holding register is empty at a frame boundary (the falling BCLK that opens the left channel), both words of that frame are sent as zeros, the WS and BCLK pattern continue unchanged, and the interrupt pulse coincides with that falling BCLK.
- R7: Such a boundary sets `underrun_o`, which stays set until `underrun_clr_i` is sampled high with no new underrun in the same cycle; `irq_o` is high for exactly one cycle per underrun frame while `underrun_o` is high.
- R8: During reset BCLK, WS and serial data are low, `underrun_o` and `irq_o` are low, and the empty holding register shows `in_ready_o` high.
- R9: When the producer always has a frame ready before each frame boundary, no underrun is flagged and no interrupt fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | BCLK half-period length minus one, in system clocks; static while running |
| in_valid_i | input | 1 | Producer offers a stereo frame |
| in_left_i | input | SAMPLE_W | Left-channel PCM word of the offered frame |
| in_right_i | input | SAMPLE_W | Right-channel PCM word of the offered frame |
| in_ready_o | output | 1 | Holding register is empty and will take the offered frame |
| underrun_clr_i | input | 1 | Clears the sticky underrun flag |
| bclk_o | output | 1 | Bit clock for the serial link |
| ws_o | output | 1 | Word select: low for left, high for right |
| sd_o | output | 1 | Serial audio data, MSB first |
| underrun_o | output | 1 | Sticky flag: a frame boundary found no data |
| irq_o | output | 1 | One-cycle pulse per underrun frame |

## Verification
The bench decodes the line the way a receiver does. At every rising BCLK it samples WS and data, closes a word at each WS edge and compares the resulting pairs against a queue of accepted frames.

Single-bit patterns at either end of a word (only the MSB set, only the LSB set) are aimed at a design that drops the one-bit delay after WS or swaps the shift direction. Such a design would shift every word by one place or mirror it. Mixed left/right patterns catch swapped channels. Three divider values, including the fastest setting, would expose a half-period counter that is off by one or a channel that is one slot too long or too short.

Stopping the producer mid-stream checks that a starved frame still carries full framing with zero words, and that the flag is sticky and clears on request. A design that stalls WS, repeats the last frame or forgets the flag would fail the frame comparison, the flag checks or the slot count.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    // Framing controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    // Width of a slot index able to count one channel of w bits
    function automatic int unsigned slot_bits(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/i2s_bclk_gen.sv
// Bit-clock generator: a half-period counter toggles a registered BCLK.
// fall_o marks the system clock edge at which BCLK goes from high to low.
module i2s_bclk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] half_div_i,
    output logic             bclk_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             bclk_q;
    logic             tick;

    // End of a half period; >= keeps the counter bounded if the limit shrinks
    assign tick = (cnt_q >= half_div_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign bclk_o = bclk_q;
    assign fall_o = tick && bclk_q;

endmodule

// File: rtl/i2s_frame_hold.sv
// One-entry frame holding register with underrun reporting.
module i2s_frame_hold #(
    parameter int unsigned SAMPLE_W = 16,
    parameter bit          IRQ_EN   = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_left_i,
    input  logic [SAMPLE_W-1:0] in_right_i,
    output logic                in_ready_o,
    input  logic                frame_start_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    input  logic                underrun_clr_i,
    output logic                underrun_o,
    output logic                irq_o
);

    logic                full_q;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                accept;
    logic                starve;
    logic                flag_q;

    assign in_ready_o = !full_q;
    assign accept     = in_valid_i && !full_q;
    assign starve     = frame_start_i && !full_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            full_q  <= 1'b0;
            left_q  <= '0;
            right_q <= '0;
        end else if (accept) begin
            full_q  <= 1'b1;
            left_q  <= in_left_i;
            right_q <= in_right_i;
        end else if (frame_start_i && full_q) begin
            full_q  <= 1'b0;
        end
    end

    // An empty register yields silence for the whole frame
    assign left_o  = full_q ? left_q  : '0;
    assign right_o = full_q ? right_q : '0;

    // Sticky flag: a new underrun wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (starve) begin
            flag_q <= 1'b1;
        end else if (underrun_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign underrun_o = flag_q;

    generate
        if (IRQ_EN) begin : g_irq
            logic irq_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    irq_q <= 1'b0;
                end else begin
                    irq_q <= starve;
                end
            end
            assign irq_o = irq_q;
        end else begin : g_no_irq
            assign irq_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/i2s_tx_fsm.sv
// Framing controller: walks the slots of each channel on falling BCLK.
module i2s_tx_fsm
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fall_i,
    output logic frame_start_o,
    output logic chan_swap_o,
    output logic shift_o,
    output logic ws_o
);

    localparam int unsigned           SLOT_W    = slot_bits(SAMPLE_W);
    localparam logic [SLOT_W-1:0]     LAST_SLOT = SLOT_W'(SAMPLE_W - 1);

    tx_state_e         state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              last;

    assign last = (slot_q == LAST_SLOT);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next state: START, SWAP_R and SWAP_L, all on a falling BCLK
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (fall_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LEFT;
                    slot_d  = '0;
                end
                ST_LEFT: begin
                    if (last) begin
                        state_d = ST_RIGHT;
                        slot_d  = '0;
                    end else begin
                        slot_d  = slot_q + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (last) begin
                        state_d = ST_LEFT;
                        slot_d  = '0;
                    end else begin
                        slot_d  = slot_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    slot_d  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        frame_start_o = 1'b0;
        chan_swap_o   = 1'b0;
        ws_o          = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                frame_start_o = fall_i;
            end
            ST_LEFT: begin
                chan_swap_o   = fall_i && last;
            end
            ST_RIGHT: begin
                frame_start_o = fall_i && last;
                ws_o          = 1'b1;
            end
            default: begin
                frame_start_o = 1'b0;
            end
        endcase
        shift_o = fall_i && !frame_start_o && !chan_swap_o;
    end

endmodule

// File: rtl/i2s_shift_out.sv
// Output shifter: loads a word at each channel boundary, emits the MSB with
// a one-slot delay so a word starts one BCLK after its WS edge.
module i2s_shift_out #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_frame_i,
    input  logic                load_pend_i,
    input  logic                shift_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sd_o
);

    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] pend_q;
    logic                sd_q;
    logic                step;

    assign step = load_frame_i || load_pend_i || shift_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            pend_q <= '0;
            sd_q   <= 1'b0;
        end else begin
            if (step) begin
                sd_q <= sh_q[SAMPLE_W-1];
            end
            if (load_frame_i) begin
                sh_q   <= left_i;
                pend_q <= right_i;
            end else if (load_pend_i) begin
                sh_q   <= pend_q;
            end else if (shift_i) begin
                sh_q   <= {sh_q[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign sd_o = sd_q;

endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned DIV_W    = 8,
    parameter bit          IRQ_EN   = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [DIV_W-1:0]    half_div_i,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_left_i,
    input  logic [SAMPLE_W-1:0] in_right_i,
    output logic                in_ready_o,
    input  logic                underrun_clr_i,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sd_o,
    output logic                underrun_o,
    output logic                irq_o
);

    logic                fall;
    logic                frame_start;
    logic                chan_swap;
    logic                shift;
    logic [SAMPLE_W-1:0] left_w;
    logic [SAMPLE_W-1:0] right_w;

    i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .half_div_i (half_div_i),
        .bclk_o     (bclk_o),
        .fall_o     (fall)
    );

    i2s_tx_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fall_i        (fall),
        .frame_start_o (frame_start),
        .chan_swap_o   (chan_swap),
        .shift_o       (shift),
        .ws_o          (ws_o)
    );

    i2s_frame_hold #(.SAMPLE_W(SAMPLE_W), .IRQ_EN(IRQ_EN)) u_hold (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .in_valid_i     (in_valid_i),
        .in_left_i      (in_left_i),
        .in_right_i     (in_right_i),
        .in_ready_o     (in_ready_o),
        .frame_start_i  (frame_start),
        .left_o         (left_w),
        .right_o        (right_w),
        .underrun_clr_i (underrun_clr_i),
        .underrun_o     (underrun_o),
        .irq_o          (irq_o)
    );

    i2s_shift_out #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_frame_i (frame_start),
        .load_pend_i  (chan_swap),
        .shift_i      (shift),
        .left_i       (left_w),
        .right_i      (right_w),
        .sd_o         (sd_o)
    );

endmodule

// File: rtl/i2s_stereo_tx_chk.sv
module i2s_stereo_tx_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [DIV_W-1:0] half_div_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             bclk_o,
    input logic             ws_o,
    input logic             sd_o,
    input logic             underrun_o,
    input logic             irq_o
);

    localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

    logic           bclk_prev;
    logic [DIV_W:0] run_q;
    logic           seen_q;

    // Length of each BCLK level, measured at the ports
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bclk_prev <= 1'b0;
            run_q     <= '0;
            seen_q    <= 1'b0;
        end else begin
            bclk_prev <= bclk_o;
            if (bclk_o != bclk_prev) begin
                run_q  <= ONE;
                seen_q <= 1'b1;
            end else begin
                run_q  <= run_q + ONE;
            end
        end
    end

    // R1: every full BCLK level lasts half_div_i + 1 cycles
    p_bclk_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && (bclk_o != bclk_prev)) |-> (run_q == ({1'b0, half_div_i} + ONE)));

    // R2: WS moves only with a falling BCLK
    p_ws_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ws_o) |-> $fell(bclk_o));

    // R3: data moves only with a falling BCLK
    p_sd_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sd_o) |-> $fell(bclk_o));

    // R5: an accepted frame occupies the holding register
    p_hold_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R6: the underrun pulse lines up with the frame-opening BCLK fall
    p_irq_at_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $fell(bclk_o));

    // R7: the pulse comes with the sticky flag and lasts one cycle
    p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> underrun_o);

    p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

endmodule

bind i2s_stereo_tx i2s_stereo_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_div_i (half_div_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .sd_o       (sd_o),
    .underrun_o (underrun_o),
    .irq_o      (irq_o)
);

// File: tb/i2s_stereo_tx_test.sv
module i2s_stereo_tx_test;

    localparam int unsigned SW = 16;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic [DW-1:0] half_div;
    logic          in_valid;
    logic [SW-1:0] in_left;
    logic [SW-1:0] in_right;
    logic          in_ready;
    logic          clr;
    logic          bclk, ws, sd, underrun, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    i2s_stereo_tx #(.SAMPLE_W(SW), .DIV_W(DW), .IRQ_EN(1'b1)) uut (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .half_div_i     (half_div),
        .in_valid_i     (in_valid),
        .in_left_i      (in_left),
        .in_right_i     (in_right),
        .in_ready_o     (in_ready),
        .underrun_clr_i (clr),
        .bclk_o         (bclk),
        .ws_o           (ws),
        .sd_o           (sd),
        .underrun_o     (underrun),
        .irq_o          (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard state
    logic [31:0] exp_q[$];
    bit          allow_gap = 1'b0;
    int          gap_cnt   = 0;
    int          pop_cnt   = 0;
    int          irq_cnt   = 0;

    // Monitor: a receiver sampling on every rising BCLK
    logic          bclk_last, ws_last, seen_change, have_rise, got_left;
    logic [SW-1:0] acc, left_word;
    int            cyc, last_rise, rises;

    always @(negedge clk) begin
        if (!rst_ni) begin
            bclk_last   = 1'b0;
            ws_last     = 1'b0;
            seen_change = 1'b0;
            have_rise   = 1'b0;
            got_left    = 1'b0;
            acc         = '0;
            left_word   = '0;
            cyc         = 0;
            last_rise   = 0;
            rises       = 0;
        end else begin
            cyc++;
            if (irq) irq_cnt++;
            if (bclk && !bclk_last) begin
                if (have_rise)
                    check((cyc - last_rise) == 2 * (int'(half_div) + 1), "R1",
                          "BCLK period", cyc - last_rise, 2 * (int'(half_div) + 1));
                have_rise = 1'b1;
                last_rise = cyc;
                if (ws != ws_last) begin
                    logic [SW-1:0] word;
                    word = {acc[SW-2:0], sd};
                    if (seen_change)
                        check(rises + 1 == SW, "R2", "BCLK periods per channel",
                              rises + 1, SW);
                    seen_change = 1'b1;
                    rises = 0;
                    if (!ws_last) begin
                        left_word = word;
                        got_left  = 1'b1;
                    end else if (got_left) begin
                        logic [31:0] pair;
                        pair = {left_word, word};
                        if (allow_gap && pair == 32'h0) begin
                            gap_cnt++;
                            check(pair == 32'h0, "R6", "starved frame words", pair, 0);
                        end else if (exp_q.size() == 0) begin
                            check(1'b0, "R9", "frame with nothing queued", pair, 0);
                        end else begin
                            logic [31:0] e;
                            e = exp_q.pop_front();
                            pop_cnt++;
                            check(pair == e, "R4", "left/right frame on the line", pair, e);
                        end
                    end
                    ws_last = ws;
                end else begin
                    acc = {acc[SW-2:0], sd};
                    rises++;
                end
            end
            bclk_last = bclk;
        end
    end

    // Driver: offer one frame, push its expectation at the handshake
    task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
        in_left  = l;
        in_right = r;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({l, r});
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R5", "ready after accept", in_ready, 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic [DW-1:0] d);
        @(negedge clk);
        rst_ni    = 1'b0;
        half_div  = d;
        allow_gap = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(bclk == 1'b0 && ws == 1'b0 && sd == 1'b0, "R8", "line idle in reset",
              {bclk, ws, sd}, 0);
        check(underrun == 1'b0 && irq == 1'b0, "R8", "flags clear in reset",
              {underrun, irq}, 0);
        check(in_ready == 1'b1, "R8", "ready in reset", in_ready, 1);
        rst_ni = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_ni   = 1'b0;
        in_valid = 1'b0;
        in_left  = '0;
        in_right = '0;
        clr      = 1'b0;
        half_div = 8'd2;

        // Phase 1: steady stream, then starvation, then restart
        do_reset(8'd2);
        for (int i = 0; i < 10; i++) begin
            logic [SW-1:0] l;
            l = SW'(16'h1357 + i * 16'h0531);
            send(l, ~l ^ SW'(i));
        end
        check(underrun == 1'b0, "R9", "no underrun while streaming", underrun, 0);
        check(irq_cnt == 0, "R9", "no interrupt while streaming", irq_cnt, 0);
        allow_gap = 1'b1;
        while (gap_cnt < 2) @(negedge clk);
        check(gap_cnt >= 2, "R6", "framing continues while starved", gap_cnt, 2);
        check(underrun == 1'b1, "R7", "flag set after starvation", underrun, 1);
        check(irq_cnt >= 1, "R7", "interrupt pulses seen", irq_cnt, 1);
        repeat (50) @(negedge clk);
        check(underrun == 1'b1, "R7", "flag sticky", underrun, 1);

        send(16'hC0DE, 16'h0BAD);
        send(16'h7E01, 16'h10E7);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(underrun == 1'b0, "R7", "flag cleared by request", underrun, 0);
        send(16'h2468, 16'h9BDF);
        send(16'hF00F, 16'h0FF0);
        allow_gap = 1'b0;
        send(16'h3C3C, 16'hA5A5);
        send(16'h4321, 16'h8765);
        check(underrun == 1'b0, "R9", "no underrun after restart", underrun, 0);
        allow_gap = 1'b1;
        drain();

        // Phase 2: fastest divider, bit-position patterns
        do_reset(8'd0);
        send(16'h8000, 16'h0001);
        send(16'h0001, 16'h8000);
        send(16'hFFFF, 16'h0000);
        send(16'h0000, 16'hFFFF);
        send(16'h5555, 16'hAAAA);
        send(16'hAAAA, 16'h5555);
        check(underrun == 1'b0, "R9", "no underrun at fastest divider", underrun, 0);
        allow_gap = 1'b1;
        drain();

        // Phase 3: slower divider
        do_reset(8'd4);
        for (int i = 0; i < 4; i++) begin
            send(SW'(16'h0102 << i), SW'(16'hFE00 >> i));
        end
        allow_gap = 1'b1;
        drain();
        check(pop_cnt == 26, "R4", "all accepted frames delivered", pop_cnt, 26);

        summary();
        $finish;
    end

endmodule